// File: doc/BRIEF.md
# Pipelined Keyed FL / Inverse-FL Mixing Layer

This block is the keyed, non-Feistel mixing layer that a 128-bit block cipher places between groups of rounds. In an 18-round datapath, one copy sits after the sixth round and one after the twelfth. A 128-bit state enters with two 64-bit layer subkeys. The upper 64-bit half passes through the forward FL transform under the first subkey. The lower 64-bit half passes through the inverse transform under the second subkey. Both results are captured in a single output register.

The layer uses no substitution tables. Each 64-bit half is cut into two 32-bit words, and each word is mixed with the other through a word-wide AND with a subkey word, a one-bit left rotation, an OR with the other subkey word, and XORs.

The block is key agile. A fresh state and a fresh pair of subkeys may be presented on every clock, and each result depends only on the inputs of its own cycle. A valid flag travels beside the data through the register. Word width, rotation amount and whether the data register is reset are parameters.

Top module: `fl_layer_pipe`

## Requirements
- R1: The upper half of `state_in` (bits 127:64) is transformed forward with `kl_a`, and the lower half (bits 63:0) is transformed inversely with `kl_b`. Within each 64-bit word or subkey, the upper 32 bits are the high word and the lower 32 bits are the low word.
- R2: In the forward transform, the output low word is the high input word ANDed with the high subkey word, rotated left by one bit, then XORed with the low input word.
- R3: In the forward transform, the output high word is the output low word from R2, ORed with the low subkey word, then XORed with the high input word. The result is placed as {high word, low word}.
- R4: In the inverse transform, the recovered high word is the input low word ORed with the low subkey word, then XORed with the input high word. The recovered low word is the recovered high word ANDed with the high subkey word, rotated left by one bit, then XORed with the input low word.
- R5: Under the same subkey, the inverse transform applied to a forward result returns the original 64-bit value, and the forward transform applied to an inverse result does the same.
- R6: `state_out` presents the transform of the `state_in`, `kl_a` and `kl_b` sampled at the previous rising edge at which `valid_in` was 1. Latency is exactly one cycle.
- R7: `valid_out` equals `valid_in` delayed by one clock. While the asynchronous active-low `rst_n` is 0, `valid_out` and `state_out` are 0.
- R8: Subkeys may change on every cycle. Back-to-back blocks with different subkeys each get their own result.
- R9: When `valid_in` is 0 at a rising edge, `state_out` keeps its previous value, regardless of `state_in`, `kl_a` and `kl_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_in | input | 1 | Input block and subkeys are valid this cycle |
| state_in | input | 128 | Input state; upper half forward, lower half inverse |
| kl_a | input | 64 | Subkey for the forward transform of the upper half |
| kl_b | input | 64 | Subkey for the inverse transform of the lower half |
| valid_out | output | 1 | Registered result is valid |
| state_out | output | 128 | Registered transformed state |

## Verification
The bench targets the cases that expose wiring and ordering slips. All-zero and all-ones subkeys catch an AND swapped for an OR, or a rotation made the wrong way. A swapped word order or a swapped subkey assignment between halves then shows as a mismatch on every random vector. A round trip feeds the forward output of one cycle back into the inverse half under the same key. A wrong-direction rotation or a step computed in the wrong order in the inverse fails to return the original value. Back-to-back subkey changes catch a result that leaks the previous cycle's key. Idle cycles with changing inputs catch a register that loads without `valid_in`. A reset asserted mid-stream catches a valid flag that survives reset.

// File: rtl/fl_layer_pkg.sv
package fl_layer_pkg;
   localparam int FL_WORD_W_DEF = 32;
   localparam int FL_ROT_DEF    = 1;

   typedef enum logic {
      FL_DIR_FWD = 1'b0,
      FL_DIR_INV = 1'b1
   } fl_dir_e;
endpackage

// File: rtl/fl_rotl.sv
module fl_rotl #(
   parameter int W = 32,
   parameter int S = 1
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   generate
      if (S < 1 || S >= W) begin : g_bad_shift
         $error("fl_rotl: shift must lie in 1..W-1");
      end
   endgenerate

   assign y = {x[W-S-1:0], x[W-1:W-S]};
endmodule

// File: rtl/fl_half_unit.sv
module fl_half_unit
   import fl_layer_pkg::*;
#(
   parameter int      WORD_W = FL_WORD_W_DEF,
   parameter int      ROT    = FL_ROT_DEF,
   parameter fl_dir_e DIR    = FL_DIR_FWD,
   localparam int     HALF_W = 2 * WORD_W
) (
   input  logic [HALF_W-1:0] din,
   input  logic [HALF_W-1:0] key,
   output logic [HALF_W-1:0] dout
);
   logic [WORD_W-1:0] d_hi, d_lo, k_hi, k_lo;
   logic [WORD_W-1:0] and_w, rot_w;

   assign d_hi = din[HALF_W-1:WORD_W];
   assign d_lo = din[WORD_W-1:0];
   assign k_hi = key[HALF_W-1:WORD_W];
   assign k_lo = key[WORD_W-1:0];

   fl_rotl #(.W(WORD_W), .S(ROT)) u_rot (.x(and_w), .y(rot_w));

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("fl_half_unit: WORD_W must be at least 2");
      end

      if (DIR == FL_DIR_FWD) begin : g_fwd
         logic [WORD_W-1:0] new_lo, new_hi;
         assign and_w  = d_hi & k_hi;
         assign new_lo = rot_w ^ d_lo;
         assign new_hi = (new_lo | k_lo) ^ d_hi;
         assign dout   = {new_hi, new_lo};
      end else begin : g_inv
         logic [WORD_W-1:0] old_hi, old_lo;
         assign old_hi = (d_lo | k_lo) ^ d_hi;
         assign and_w  = old_hi & k_hi;
         assign old_lo = rot_w ^ d_lo;
         assign dout   = {old_hi, old_lo};
      end
   endgenerate
endmodule

// File: rtl/fl_stage_reg.sv
module fl_stage_reg #(
   parameter int DATA_W     = 128,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_d,
   input  logic [DATA_W-1:0] data_d,
   output logic              valid_q,
   output logic [DATA_W-1:0] data_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
   end

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fl_stage_reg: DATA_W must be positive");
      end

      if (RESET_DATA) begin : g_rst_data
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       data_q <= '0;
            else if (valid_d) data_q <= data_d;
         end
      end else begin : g_free_data
         always_ff @(posedge clk) begin
            if (valid_d) data_q <= data_d;
         end
      end
   endgenerate

   // R7
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (valid_q == $past(valid_d)));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(valid_d)) |-> $stable(data_q));
endmodule

// File: rtl/fl_layer_pipe.sv
module fl_layer_pipe
   import fl_layer_pkg::*;
#(
   parameter int  WORD_W     = FL_WORD_W_DEF,
   parameter int  ROT        = FL_ROT_DEF,
   parameter bit  RESET_DATA = 1'b1,
   localparam int HALF_W     = 2 * WORD_W,
   localparam int BLK_W      = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [BLK_W-1:0]  state_in,
   input  logic [HALF_W-1:0] kl_a,
   input  logic [HALF_W-1:0] kl_b,
   output logic              valid_out,
   output logic [BLK_W-1:0]  state_out
);
   logic [HALF_W-1:0] fwd_half, inv_half;

   // R1: upper half forward with kl_a, lower half inverse with kl_b
   fl_half_unit #(.WORD_W(WORD_W), .ROT(ROT), .DIR(FL_DIR_FWD)) u_fwd (
      .din  (state_in[BLK_W-1:HALF_W]),
      .key  (kl_a),
      .dout (fwd_half)
   );

   fl_half_unit #(.WORD_W(WORD_W), .ROT(ROT), .DIR(FL_DIR_INV)) u_inv (
      .din  (state_in[HALF_W-1:0]),
      .key  (kl_b),
      .dout (inv_half)
   );

   fl_stage_reg #(.DATA_W(BLK_W), .RESET_DATA(RESET_DATA)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid_d (valid_in),
      .data_d  ({fwd_half, inv_half}),
      .valid_q (valid_out),
      .data_q  (state_out)
   );

   function automatic logic [WORD_W-1:0] rot_w(input logic [WORD_W-1:0] v);
      return (v << ROT) | (v >> (WORD_W - ROT));
   endfunction

   function automatic logic [HALF_W-1:0] undo_fwd(input logic [HALF_W-1:0] y,
                                                  input logic [HALF_W-1:0] k);
      logic [WORD_W-1:0] hi, lo;
      hi = (y[WORD_W-1:0] | k[WORD_W-1:0]) ^ y[HALF_W-1:WORD_W];
      lo = rot_w(hi & k[HALF_W-1:WORD_W]) ^ y[WORD_W-1:0];
      return {hi, lo};
   endfunction

   function automatic logic [HALF_W-1:0] undo_inv(input logic [HALF_W-1:0] x,
                                                  input logic [HALF_W-1:0] k);
      logic [WORD_W-1:0] hi, lo;
      lo = rot_w(x[HALF_W-1:WORD_W] & k[HALF_W-1:WORD_W]) ^ x[WORD_W-1:0];
      hi = (lo | k[WORD_W-1:0]) ^ x[HALF_W-1:WORD_W];
      return {hi, lo};
   endfunction

   // R5
   fwd_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid_in)) |->
      (undo_fwd(state_out[BLK_W-1:HALF_W], $past(kl_a)) == $past(state_in[BLK_W-1:HALF_W])));

   // R5
   inv_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(valid_in)) |->
      (undo_inv(state_out[HALF_W-1:0], $past(kl_b)) == $past(state_in[HALF_W-1:0])));
endmodule

// File: tb/fl_layer_pipe_bench.sv
module fl_layer_pipe_bench;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         valid_in;
   logic [127:0] state_in;
   logic [63:0]  kl_a, kl_b;
   logic         valid_out;
   logic [127:0] state_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic         m_valid;
   logic [127:0] m_data;

   always #2 clk = ~clk;

   fl_layer_pipe u_fl_layer_pipe (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .state_in(state_in),
      .kl_a(kl_a), .kl_b(kl_b), .valid_out(valid_out), .state_out(state_out)
   );

   function automatic logic [31:0] rl1(input logic [31:0] v);
      return (v << 1) | (v >> 31);
   endfunction

   function automatic logic [63:0] ref_fwd(input logic [63:0] x, input logic [63:0] k);
      logic [31:0] yr, yl;
      yr = rl1(x[63:32] & k[63:32]) ^ x[31:0];
      yl = (yr | k[31:0]) ^ x[63:32];
      return {yl, yr};
   endfunction

   function automatic logic [63:0] ref_inv(input logic [63:0] y, input logic [63:0] k);
      logic [31:0] xl, xr;
      xl = (y[31:0] | k[31:0]) ^ y[63:32];
      xr = rl1(xl & k[63:32]) ^ y[31:0];
      return {xl, xr};
   endfunction

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, compare at the next falling edge.
   task automatic step(input string req, input logic v, input logic [127:0] s,
                       input logic [63:0] ka, input logic [63:0] kb);
      valid_in = v; state_in = s; kl_a = ka; kl_b = kb;
      @(posedge clk);
      m_valid = v;
      if (v) m_data = {ref_fwd(s[127:64], ka), ref_inv(s[63:0], kb)};
      @(negedge clk);
      check({req, " (R7 valid)"}, {127'd0, valid_out}, {127'd0, m_valid});
      check(req, state_out, m_data);
   endtask

   initial begin
      #(4 * 20000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] x, k, y, p;
      rst_n = 1'b0; valid_in = 1'b0; state_in = '1; kl_a = '1; kl_b = '1;
      m_valid = 1'b0; m_data = '0;
      repeat (3) @(negedge clk);
      // R7 reset state
      check("R7 reset valid", {127'd0, valid_out}, 128'd0);
      check("R7 reset data", state_out, 128'd0);
      rst_n = 1'b1;

      // R2 R3 zero subkeys: low word passes, high word becomes hi^lo
      step("R2 zero key", 1'b1, 128'h0123456789ABCDEF_FEDCBA9876543210, 64'd0, 64'd0);
      check("R3 zero key hi word", {96'd0, state_out[127:96]}, {96'd0, 32'h01234567 ^ 32'h89ABCDEF});
      // R2 R3 all-ones subkeys: high word inverted
      step("R3 ones key", 1'b1, 128'h80000001_00000000_FFFFFFFF_12345678, '1, '1);
      check("R2 ones key lo word", {96'd0, state_out[95:64]}, {96'd0, 32'h00000003});
      // R4 inverse half alone with distinct key
      step("R4 inverse", 1'b1, {64'd0, 64'hDEADBEEF_CAFEF00D}, 64'd0, 64'hF0F0F0F0_0F0F0F0F);
      // R1 swapped keys must differ between halves
      step("R1 half/key map", 1'b1, {64'hAAAA5555_3333CCCC, 64'hAAAA5555_3333CCCC},
           64'h12345678_9ABCDEF0, 64'h0FEDCBA9_87654321);

      // R8 back-to-back random blocks, new keys each cycle
      for (int i = 0; i < 200; i++)
         step("R8 agile", 1'b1, {r64(), r64()}, r64(), r64());

      // R9 idle cycles with changing inputs
      for (int i = 0; i < 20; i++)
         step("R9 hold", 1'b0, {r64(), r64()}, r64(), r64());
      // R6 mixed valid pattern
      for (int i = 0; i < 200; i++)
         step("R6 mixed", ($urandom % 3) != 0, {r64(), r64()}, r64(), r64());

      // R5 round trip: forward result fed to the inverse half under the same key
      for (int i = 0; i < 50; i++) begin
         x = r64(); k = r64(); p = r64();
         step("R5 fwd leg", 1'b1, {x, p}, k, r64());
         y = state_out[127:64];
         step("R5 inv leg", 1'b1, {r64(), y}, r64(), k);
         check("R5 roundtrip", {64'd0, state_out[63:0]}, {64'd0, x});
      end

      // R7 reset mid-stream
      step("R7 before reset", 1'b1, {r64(), r64()}, r64(), r64());
      valid_in = 1'b1;
      rst_n = 1'b0;
      #1;
      check("R7 async reset valid", {127'd0, valid_out}, 128'd0);
      check("R7 async reset data", state_out, 128'd0);
      @(negedge clk);
      rst_n = 1'b1;
      m_valid = 1'b0; m_data = '0;
      step("R7 after reset", 1'b1, {r64(), r64()}, r64(), r64());

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule